// File: doc/BRIEF.md
# Bit-Serial Configuration Loader

This block configures a programmable target device through its bit-serial configuration port. A one-cycle `start` pulse, together with a total byte count, begins a load. The block pulls the active-low program line, waits for the target to drive its active-low init line low, and then releases program. It then waits for init to return high and takes configuration bytes from a valid/ready byte stream. Each byte is shifted out most-significant bit first, and the target samples data on the rising edge of the configuration clock.

Once the last byte is sent, the block holds the data line high and keeps pulsing the configuration clock until the target raises done. The configuration clock comes from the system clock through a half-period divider, so the block has a single clock domain. Each wait phase uses the same timeout counter, which restarts at the start of every phase. If a limit expires, the load ends with a code that identifies the phase. Before each byte is taken, the block checks for an integrity fault: init low while done is still low. In that case it ends the load at once. Every load finishes with a one-cycle completion pulse that carries a result code.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset and whenever idle: `prog_n`=1, `cfg_clk`=1, `busy`=0, `s_ready`=0, `cpl_valid`=0.
- R2: A `start` pulse in idle drives `prog_n` low from the next cycle. `prog_n` stays low until `init_n` is seen low, and rises one cycle after that.
- R3: After program is released, no data is clocked and `s_ready` stays 0 until `init_n` is seen high. `s_ready` is 1 only in the data phase, with the shifter empty and bytes still owed.
- R4: Each wait phase lasts at most `TIMEOUT_CYC` cycles. If `init_n` does not fall, the load ends with code 1, and `prog_n` has then been low for exactly `TIMEOUT_CYC` cycles. If `init_n` does not rise, the code is 2 after exactly `TIMEOUT_CYC` cycles. If done does not rise, the code is 3. Codes are 3 bits wide, and 4 is the highest code issued.
- R5: Bytes are sent in stream order, each as eight clock pulses, most-significant bit first.
- R6: Each low phase of `cfg_clk` lasts exactly `HALF_DIV` system cycles, and each high phase lasts at least `HALF_DIV` cycles. `cfg_dout` changes only while `cfg_clk` is low.
- R7: Before each byte is accepted, `init_n`=0 together with `done`=0 ends the load with code 4. No further byte is accepted.
- R8: After the last byte, `cfg_dout` is 1 for every further clock pulse. Pulses continue until `done` is seen high, and the load then ends with code 0. If done is already high, no further pulse is given.
- R9: `cpl_valid` is high for exactly one cycle. In that cycle `busy`=0 and `prog_n`=1.
- R10: A byte count of zero goes directly from the init handshake to the done wait, with no data pulses.
- R11: A `start` pulse while `busy` is 1 has no effect on the running load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle load request, taken only when idle |
| byte_total | input | CNT_W | Number of bytes in the load, captured with `start` |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data |
| s_ready | output | 1 | Byte stream ready |
| init_n | input | 1 | Target init line, active low |
| done | input | 1 | Target done line, active high |
| prog_n | output | 1 | Target program line, active low |
| cfg_clk | output | 1 | Configuration clock; target samples on its rising edge |
| cfg_dout | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_code | output | 3 | Result: 0 ok, 1 init-fall timeout, 2 init-rise timeout, 3 done timeout, 4 integrity fault |

## Verification
The assertions check these properties on every cycle:
- `s_ready` is raised only mid-load with program released.
- The completion pulse is single and coincides with idle.
- Serial data never moves while the configuration clock is high.
- The program line stays low no longer than the timeout window.

Only the bench scenarios can show the following: the bit order and byte order, the exact timeout lengths, the count of flush pulses after done, that a load stops at the integrity fault, and that `start` is ignored during a load. Each of these needs a modelled target driving init and done in response to the block.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM,
        ST_INIT,
        ST_FEED,
        ST_SHIFT,
        ST_FLUSH
    } ld_state_e;

    typedef enum logic [2:0] {
        RC_OK           = 3'd0,
        RC_TO_INIT_LOW  = 3'd1,
        RC_TO_INIT_HIGH = 3'd2,
        RC_TO_DONE      = 3'd3,
        RC_CRC          = 3'd4
    } ld_rc_e;

    typedef struct packed {
        logic   valid;
        ld_rc_e code;
    } ld_cpl_t;

    localparam int BYTE_BITS = 8;
    localparam logic [BYTE_BITS-1:0] FLUSH_BYTE = '1;

    // integrity fault: target signals error (init low) before it reports done
    function automatic logic crc_fault(input logic init_n, input logic done);
        return !init_n && !done;
    endfunction

endpackage

// File: rtl/cfg_half_div.sv
module cfg_half_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_end
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DW'(1);
        end
    end

    assign half_end = run && (cnt == LAST);
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter
    import cfg_ld_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [BYTE_BITS-1:0] load_byte,
    input  logic                 clear,
    input  logic                 half_end,
    output logic                 active,
    output logic                 sclk,
    output logic                 sdout,
    output logic                 byte_done
);
    localparam int LW = $clog2(BYTE_BITS + 1);

    logic [BYTE_BITS-1:0] sh;
    logic [LW-1:0]        left;
    logic                 ph_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            left    <= '0;
            ph_high <= 1'b0;
            active  <= 1'b0;
            sclk    <= 1'b1;
            sdout   <= 1'b0;
        end else if (clear) begin
            active  <= 1'b0;
            ph_high <= 1'b0;
            sclk    <= 1'b1;
        end else if (load) begin
            sh      <= load_byte;
            left    <= LW'(BYTE_BITS);
            ph_high <= 1'b0;
            active  <= 1'b1;
            sclk    <= 1'b0;
            sdout   <= load_byte[BYTE_BITS-1];
        end else if (active && half_end) begin
            if (!ph_high) begin
                ph_high <= 1'b1;
                sclk    <= 1'b1;
            end else if (left == LW'(1)) begin
                active  <= 1'b0;
                left    <= '0;
                ph_high <= 1'b0;
            end else begin
                left    <= left - LW'(1);
                ph_high <= 1'b0;
                sclk    <= 1'b0;
                sh      <= {sh[BYTE_BITS-2:0], 1'b0};
                sdout   <= sh[BYTE_BITS-2];
            end
        end
    end

    assign byte_done = active && half_end && ph_high && (left == LW'(1));
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [TW-1:0] LIM = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_ld_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int TIMEOUT_CYC = 500000,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_total,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    input  logic             init_n,
    input  logic             done,
    output logic             prog_n,
    output logic             cfg_clk,
    output logic             cfg_dout,
    output logic             busy,
    output logic             cpl_valid,
    output logic [2:0]       cpl_code
);
    ld_state_e            st, st_nxt;
    logic [CNT_W-1:0]     remaining;
    ld_cpl_t              cpl_q, cpl_d;

    logic                 sh_load, sh_clear, sh_active, sh_byte_done, half_end;
    logic [BYTE_BITS-1:0] sh_byte;
    logic                 tmo, tmr_clr, fault;

    assign fault = crc_fault(init_n, done);

    cfg_half_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst(rst), .run(sh_active), .half_end(half_end)
    );

    cfg_bit_shifter u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .load_byte(sh_byte),
        .clear(sh_clear), .half_end(half_end), .active(sh_active),
        .sclk(cfg_clk), .sdout(cfg_dout), .byte_done(sh_byte_done)
    );

    cfg_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .expired(tmo)
    );

    always_comb begin
        st_nxt     = st;
        sh_load    = 1'b0;
        sh_byte    = s_data;
        sh_clear   = 1'b0;
        cpl_d      = '{valid: 1'b0, code: RC_OK};
        case (st)
            ST_IDLE:  if (start) st_nxt = ST_PGM;
            ST_PGM: begin
                if (!init_n)  st_nxt = ST_INIT;
                else if (tmo) cpl_d = '{valid: 1'b1, code: RC_TO_INIT_LOW};
            end
            ST_INIT: begin
                if (init_n)   st_nxt = ST_FEED;
                else if (tmo) cpl_d = '{valid: 1'b1, code: RC_TO_INIT_HIGH};
            end
            ST_FEED: begin
                if (remaining == '0) begin
                    st_nxt = ST_FLUSH;
                end else if (fault) begin
                    cpl_d = '{valid: 1'b1, code: RC_CRC};
                end else if (s_valid) begin
                    sh_load = 1'b1;
                    st_nxt  = ST_SHIFT;
                end
            end
            ST_SHIFT: if (sh_byte_done) st_nxt = ST_FEED;
            ST_FLUSH: begin
                if (done) begin
                    sh_clear = 1'b1;
                    cpl_d    = '{valid: 1'b1, code: RC_OK};
                end else if (tmo) begin
                    sh_clear = 1'b1;
                    cpl_d    = '{valid: 1'b1, code: RC_TO_DONE};
                end else if (!sh_active) begin
                    sh_load = 1'b1;
                    sh_byte = FLUSH_BYTE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (cpl_d.valid) st_nxt = ST_IDLE;
    end

    assign tmr_clr = (st_nxt != st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            remaining <= '0;
            cpl_q     <= '{valid: 1'b0, code: RC_OK};
        end else begin
            st          <= st_nxt;
            cpl_q.valid <= cpl_d.valid;
            if (cpl_d.valid) cpl_q.code <= cpl_d.code;
            if (st == ST_IDLE && start) begin
                remaining <= byte_total;
            end else if (st == ST_FEED && sh_load) begin
                remaining <= remaining - CNT_W'(1);
            end
        end
    end

    assign s_ready   = (st == ST_FEED) && (remaining != '0) && !fault;
    assign prog_n    = (st != ST_PGM);
    assign busy      = (st != ST_IDLE);
    assign cpl_valid = cpl_q.valid;
    assign cpl_code  = cpl_q.code;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int TIMEOUT_CYC = 500000
) (
    input logic       clk,
    input logic       rst,
    input logic       s_ready,
    input logic       prog_n,
    input logic       cfg_clk,
    input logic       cfg_dout,
    input logic       busy,
    input logic       cpl_valid,
    input logic [2:0] cpl_code
);
    int prog_low_cnt;

    always_ff @(posedge clk) begin
        if (rst || prog_n) prog_low_cnt <= 0;
        else               prog_low_cnt <= prog_low_cnt + 1;
    end

    assert_idle_clk_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_clk && prog_n && !s_ready));

    assert_prog_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> busy);

    assert_ready_phase_R3: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (busy && prog_n));

    assert_prog_window_R4: assert property (@(posedge clk) disable iff (rst)
        prog_low_cnt <= TIMEOUT_CYC);

    assert_code_legal_R4: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (cpl_code <= 3'd4));

    assert_dout_low_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_dout) |-> !cfg_clk);

    assert_cpl_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> !cpl_valid);

    assert_cpl_idle_R9: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (!busy && prog_n));
endmodule

bind cfg_serial_loader cfg_loader_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst(rst), .s_ready(s_ready), .prog_n(prog_n),
    .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .busy(busy),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    localparam int H     = 2;
    localparam int T     = 200;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CW-1:0] byte_total = '0;
    logic s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic init_n = 1'b1;
    logic done = 1'b0;
    logic s_ready, prog_n, cfg_clk, cfg_dout, busy, cpl_valid;
    logic [2:0] cpl_code;

    cfg_serial_loader #(.HALF_DIV(H), .TIMEOUT_CYC(T), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .byte_total(byte_total),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .init_n(init_n), .done(done), .prog_n(prog_n), .cfg_clk(cfg_clk),
        .cfg_dout(cfg_dout), .busy(busy), .cpl_valid(cpl_valid), .cpl_code(cpl_code)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bitcnt = 0;
    logic cap_bits [0:1023];
    int lowrun = 0;
    int lowbad = 0;
    logic [7:0] pay [0:31];

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            summary();
        end
    end

    // target model samples data on rising configuration clock
    always @(posedge cfg_clk) begin
        if (!rst && bitcnt < 1024) begin
            cap_bits[bitcnt] = cfg_dout;
            bitcnt++;
        end
    end

    // low-phase length monitor (R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (!cfg_clk) lowrun++;
            else begin
                if (lowrun != 0 && lowrun != H && !cpl_valid) lowbad++;
                lowrun = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int j);
        return b[7-j];
    endfunction

    task automatic pulse_start(input int n);
        @(negedge clk);
        start = 1'b1;
        byte_total = CW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_cpl(output int code);
        int g = 0;
        while (!cpl_valid && g < 20000) begin
            @(negedge clk);
            g++;
        end
        code = cpl_valid ? int'(cpl_code) : -1;
    endtask

    task automatic run_load(input int n, input int k, input int d1, input int d2, input bit dbl_start);
        int code;
        int g;
        int bad;
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
        bitcnt = 0;
        done = 1'b0;
        init_n = 1'b1;
        pulse_start(n);
        check("R2 prog_n low after start", int'(prog_n), 0);
        check("R3 no ready while programming", int'(s_ready), 0);
        repeat (d1) @(negedge clk);
        check("R2 prog_n held until init falls", int'(prog_n), 0);
        init_n = 1'b0;
        @(negedge clk);
        check("R2 prog_n released after init low", int'(prog_n), 1);
        repeat (d2) @(negedge clk);
        check("R3 no ready before init high", int'(s_ready), 0);
        check("R3 no data before init high", bitcnt, 0);
        init_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            g = 0;
            while (!s_ready && g < 5000) begin
                @(negedge clk);
                g++;
            end
            s_valid = 1'b1;
            s_data = pay[i];
            @(negedge clk);
            s_valid = 1'b0;
            if (dbl_start && i == 0) begin
                start = 1'b1;
                byte_total = CW'(n + 3);
                @(negedge clk);
                start = 1'b0;
            end
        end
        g = 0;
        while (bitcnt < 8 * n + k && g < 5000) begin
            @(negedge clk);
            g++;
        end
        done = 1'b1;
        wait_cpl(code);
        check("R8 success code", code, 0);
        check("R9 busy low at completion", int'(busy), 0);
        check("R9 prog_n high at completion", int'(prog_n), 1);
        check("R8 flush pulse count / R11 length kept", bitcnt, 8 * n + k);
        bad = 0;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++)
                if (cap_bits[8*i+j] !== exp_bit(pay[i], j)) bad++;
        check("R5 MSB-first byte order", bad, 0);
        bad = 0;
        for (int i = 8 * n; i < bitcnt; i++) if (cap_bits[i] !== 1'b1) bad++;
        check("R8 data high during flush", bad, 0);
        @(negedge clk);
        check("R9 single completion pulse", int'(cpl_valid), 0);
    endtask

    initial begin
        int code;
        int cnt;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset prog_n", int'(prog_n), 1);
        check("R1 reset cfg_clk", int'(cfg_clk), 1);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset s_ready", int'(s_ready), 0);
        check("R1 reset cpl_valid", int'(cpl_valid), 0);

        // directed: double start during a load (R11), done arrives immediately
        run_load(3, 0, 4, 4, 1'b1);

        // random loads
        for (int it = 0; it < 6; it++)
            run_load(1 + int'($urandom % 8), int'($urandom % 5),
                     1 + int'($urandom % 20), 1 + int'($urandom % 20), 1'b0);

        // zero-length load with done already high (R10)
        bitcnt = 0;
        done = 1'b1;
        pulse_start(0);
        repeat (3) @(negedge clk);
        init_n = 1'b0;
        repeat (3) @(negedge clk);
        init_n = 1'b1;
        wait_cpl(code);
        check("R10 zero-length completes ok", code, 0);
        check("R10 zero-length no pulses", bitcnt, 0);
        done = 1'b0;

        // init never falls (R4 code 1, exact window)
        @(negedge clk);
        pulse_start(1);
        cnt = 0;
        while (!cpl_valid && cnt < 5000) begin
            if (!prog_n) cnt++;
            @(negedge clk);
        end
        check("R4 init-fall timeout code", int'(cpl_code), 1);
        check("R4 init-fall window length", cnt, T);

        // init never rises (R4 code 2)
        @(negedge clk);
        pulse_start(1);
        repeat (2) @(negedge clk);
        init_n = 1'b0;
        @(negedge clk);
        cnt = 0;
        while (!cpl_valid && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
        check("R4 init-rise timeout code", int'(cpl_code), 2);
        check("R4 init-rise window length", cnt, T);
        init_n = 1'b1;

        // integrity fault after two bytes (R7)
        @(negedge clk);
        bitcnt = 0;
        pulse_start(4);
        repeat (2) @(negedge clk);
        init_n = 1'b0;
        repeat (2) @(negedge clk);
        init_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            cnt = 0;
            while (!s_ready && cnt < 5000) begin
                @(negedge clk);
                cnt++;
            end
            s_valid = 1'b1;
            s_data = 8'hA5;
            @(negedge clk);
            s_valid = 1'b0;
        end
        init_n = 1'b0;
        wait_cpl(code);
        check("R7 integrity fault code", code, 4);
        check("R7 no byte after fault", bitcnt, 16);
        init_n = 1'b1;

        // done never rises (R4 code 3)
        @(negedge clk);
        bitcnt = 0;
        pulse_start(1);
        repeat (2) @(negedge clk);
        init_n = 1'b0;
        repeat (2) @(negedge clk);
        init_n = 1'b1;
        cnt = 0;
        while (!s_ready && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        s_valid = 1'b1;
        s_data = 8'h00;
        @(negedge clk);
        s_valid = 1'b0;
        wait_cpl(code);
        check("R4 done timeout code", code, 3);
        check("R8 flush pulses issued while waiting", int'(bitcnt > 8), 1);
        cnt = 0;
        for (int i = 8; i < bitcnt; i++) if (cap_bits[i] !== 1'b1) cnt++;
        check("R8 flush data high", cnt, 0);

        @(negedge clk);
        check("R1 idle clock high", int'(cfg_clk), 1);
        check("R6 low phase length", lowbad, 0);
        summary();
    end
endmodule